// File: doc/BRIEF.md
# Set-Associative Cache Tag Array with Saturating Age Replacement

This block keeps the tag state for one bank of a set-associative cache. Every way of every set holds a valid flag, a dirty flag, a tag and a small age counter. A requester presents a lookup made of a set index, a tag and a write flag. One cycle later the block reports whether the lookup hit, which way hit, and which way it would replace. In the same cycle it states what the memory side must do: write back a dirty line, forward a write, or fetch a line.

Replacement uses ages. A hit clears the age of its way. Every other valid way in the set ages by one on each lookup, and the count stops at its maximum. An elaboration parameter chooses between write-back and write-through behaviour. The miss-tracking logic outside the block later returns a fill, which installs a tag into a chosen way. Data storage, miss tracking and bank arbitration sit outside this block.

Top module: `cache_tag_array`

## Requirements
- R1: After reset every way is invalid, clean and aged zero. The first lookup to any set misses and names way 0 as victim.
- R2: A lookup hits when a valid way of the addressed set holds the lookup tag. The result reports the hit and the index of that way.
- R3: On each lookup the hit way's age becomes 0. Every other valid way in the set ages by one, saturating at 2^AGE_W-1. Invalid ways keep their age.
- R4: The victim is the lowest-index invalid way when one exists. Otherwise it is the first valid way, in ascending index, whose updated age is strictly larger than that of all lower ways. It is way 0 if every age is 0.
- R5: In write-back mode a write hit sets that way's dirty flag and issues no memory request.
- R6: In write-back mode, a miss that finds no invalid way and a dirty victim raises evict_valid. It carries the victim's line address {stored tag, set, BANK_ID, OFFSET_W zero bits} alongside the line fetch.
- R7: In write-through mode a write hit issues a memory write to the line address rebuilt from set, bank and stored tag, and reports res_done.
- R8: In write-through mode a write miss issues a memory write and reports res_done. It allocates nothing, so a later read of that tag still misses.
- R9: A read miss, or a write-back write miss, issues a fetch (mem_req_write=0) to {lookup tag, set, BANK_ID, zero offset} and leaves res_done low. A hit reports res_done high.
- R10: A fill makes the target way valid and clean, loads its tag and clears its age. While fill_valid is high, lk_ready is low.
- R11: All results are registered. res_valid, evict_valid and mem_req_valid are high exactly in the cycle after a lookup is accepted (lk_valid and lk_ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be taken this cycle |
| lk_set | input | SET_W | Set index of the lookup |
| lk_tag | input | TAG_W | Tag of the lookup |
| lk_write | input | 1 | Lookup is a store |
| fill_valid | input | 1 | Install a line |
| fill_set | input | SET_W | Set of the line to install |
| fill_way | input | WAY_W | Way receiving the line |
| fill_tag | input | TAG_W | Tag of the installed line |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_way | output | WAY_W | Way that hit |
| res_victim | output | WAY_W | Way chosen for replacement |
| res_done | output | 1 | Requester may complete now |
| evict_valid | output | 1 | Dirty line must be written back |
| evict_addr | output | ADDR_W | Address of the dirty line |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_write | output | 1 | 1 for forwarded write, 0 for line fetch |
| mem_req_addr | output | ADDR_W | Memory request line address |

## Verification
The bench aims at age saturation. A counter that wraps instead of stopping would make a long-idle way look freshly used and push the victim back to way 0. It targets ties among equal ages, where a design that takes the last maximum or uses a non-strict compare names a higher way. It forces full sets of dirty lines, where a missing writeback would lose data and a writeback on a hit would add traffic. It also covers write-through store misses, where a design that allocated the way would make the next read hit wrongly. Two instances, one per write policy, receive the same random traffic and are compared with bench models of each policy.

// File: rtl/cta_pkg.sv
package cta_pkg;
   typedef enum logic [1:0] {
      MK_NONE  = 2'd0,
      MK_FETCH = 2'd1,
      MK_WRITE = 2'd2
   } mem_kind_e;
endpackage

// File: rtl/cta_age_calc.sv
module cta_age_calc #(
   parameter int WAYS  = 4,
   parameter int AGE_W = 2
) (
   input  logic [WAYS-1:0]            way_valid,
   input  logic [WAYS-1:0]            way_match,
   input  logic [WAYS-1:0][AGE_W-1:0] age_in,
   output logic [WAYS-1:0][AGE_W-1:0] age_out
);
   localparam logic [AGE_W-1:0] AGE_TOP = '1;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign age_out[w] = !way_valid[w]        ? age_in[w] :
                          way_match[w]         ? '0 :
                          (age_in[w] == AGE_TOP) ? AGE_TOP :
                          age_in[w] + 1'b1;
   end
endmodule

// File: rtl/cta_victim.sv
module cta_victim #(
   parameter int WAYS  = 4,
   parameter int AGE_W = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]            way_valid,
   input  logic [WAYS-1:0][AGE_W-1:0] way_age,
   output logic [WAY_W-1:0]           victim,
   output logic                       any_free
);
   logic [WAY_W-1:0] oldest;
   logic [AGE_W-1:0] oldest_age;
   logic [WAY_W-1:0] free_way;

   always_comb begin
      oldest     = '0;
      oldest_age = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (way_valid[w] && (way_age[w] > oldest_age)) begin
            oldest_age = way_age[w];
            oldest     = WAY_W'(w);
         end
      end
   end

   always_comb begin
      free_way = '0;
      any_free = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!way_valid[w]) begin
            free_way = WAY_W'(w);
            any_free = 1'b1;
         end
      end
   end

   assign victim = any_free ? free_way : oldest;
endmodule

// File: rtl/cta_state.sv
module cta_state #(
   parameter int SETS  = 8,
   parameter int WAYS  = 4,
   parameter int TAG_W = 24,
   parameter int AGE_W = 2,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [SET_W-1:0]           rd_set,
   output logic [WAYS-1:0]            rd_valid,
   output logic [WAYS-1:0]            rd_dirty,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
   output logic [WAYS-1:0][AGE_W-1:0] rd_age,
   input  logic                       upd_en,
   input  logic [SET_W-1:0]           upd_set,
   input  logic [WAYS-1:0][AGE_W-1:0] upd_age,
   input  logic                       mark_dirty,
   input  logic [WAY_W-1:0]           mark_way,
   input  logic                       fill_en,
   input  logic [SET_W-1:0]           fill_set,
   input  logic [WAY_W-1:0]           fill_way,
   input  logic [TAG_W-1:0]           fill_tag
);
   logic [SETS-1:0][WAYS-1:0]            v_q;
   logic [SETS-1:0][WAYS-1:0]            d_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] t_q;
   logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         d_q <= '0;
         t_q <= '0;
         a_q <= '0;
      end else begin
         if (upd_en) begin
            a_q[upd_set] <= upd_age;
            if (mark_dirty) d_q[upd_set][mark_way] <= 1'b1;
         end
         if (fill_en) begin
            v_q[fill_set][fill_way] <= 1'b1;
            d_q[fill_set][fill_way] <= 1'b0;
            t_q[fill_set][fill_way] <= fill_tag;
            a_q[fill_set][fill_way] <= '0;
         end
      end
   end

   assign rd_valid = v_q[rd_set];
   assign rd_dirty = d_q[rd_set];
   assign rd_tag   = t_q[rd_set];
   assign rd_age   = a_q[rd_set];

   // R10
   fill_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> v_q[$past(fill_set)][$past(fill_way)]
                  && !d_q[$past(fill_set)][$past(fill_way)]
                  && (a_q[$past(fill_set)][$past(fill_way)] == '0)
                  && (t_q[$past(fill_set)][$past(fill_way)] == $past(fill_tag)));

   for (genvar s = 0; s < SETS; s++) begin : g_set_chk
      for (genvar w = 0; w < WAYS; w++) begin : g_way_chk
         // R3
         age_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(a_q[s][w]) |-> (a_q[s][w] == '0)
                                    || (a_q[s][w] == $past(a_q[s][w]) + 1'b1));
      end
   end
endmodule

// File: rtl/cache_tag_array.sv
module cache_tag_array
   import cta_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int SETS          = 8,
   parameter int WAYS          = 4,
   parameter int OFFSET_W      = 4,
   parameter int BANK_W        = 1,
   parameter int BANK_ID       = 1,
   parameter int AGE_W         = 2,
   parameter bit WRITE_THROUGH = 1'b0,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int TAG_W = ADDR_W - OFFSET_W - BANK_W - SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   output logic              lk_ready,
   input  logic [SET_W-1:0]  lk_set,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic              lk_write,
   input  logic              fill_valid,
   input  logic [SET_W-1:0]  fill_set,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [TAG_W-1:0]  fill_tag,
   output logic              res_valid,
   output logic              res_hit,
   output logic [WAY_W-1:0]  res_way,
   output logic [WAY_W-1:0]  res_victim,
   output logic              res_done,
   output logic              evict_valid,
   output logic [ADDR_W-1:0] evict_addr,
   output logic              mem_req_valid,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr
);
   localparam logic [BANK_W-1:0] BANK_SEL = BANK_W'(BANK_ID);

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (OFFSET_W < 1 || BANK_W < 1 || AGE_W < 1) begin : g_bad_fields
      $error("OFFSET_W, BANK_W and AGE_W must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen fields");
   end

   function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                   input logic [SET_W-1:0] s);
      return {t, s, BANK_SEL, {OFFSET_W{1'b0}}};
   endfunction

   logic                       accept;
   logic [WAYS-1:0]            rd_valid, rd_dirty, match;
   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic [WAYS-1:0][AGE_W-1:0] rd_age, new_age;
   logic                       hit, any_free;
   logic [WAY_W-1:0]           hit_way, victim;
   mem_kind_e                  kind_n, kind_q;
   logic                       done_n, evict_n, mark_dirty;
   logic [ADDR_W-1:0]          evict_addr_n, mem_addr_n;

   assign lk_ready = !fill_valid;
   assign accept   = lk_valid && lk_ready;

   cta_state #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .AGE_W(AGE_W)
   ) u_state (
      .clk(clk), .rst_n(rst_n),
      .rd_set(lk_set), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
      .rd_tag(rd_tag), .rd_age(rd_age),
      .upd_en(accept), .upd_set(lk_set), .upd_age(new_age),
      .mark_dirty(mark_dirty), .mark_way(hit_way),
      .fill_en(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
      .fill_tag(fill_tag)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = rd_valid[w] && (rd_tag[w] == lk_tag);
   end

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end
   assign hit = |match;

   cta_age_calc #(.WAYS(WAYS), .AGE_W(AGE_W)) u_age (
      .way_valid(rd_valid), .way_match(match),
      .age_in(rd_age), .age_out(new_age)
   );

   cta_victim #(.WAYS(WAYS), .AGE_W(AGE_W)) u_victim (
      .way_valid(rd_valid), .way_age(new_age),
      .victim(victim), .any_free(any_free)
   );

   assign mem_addr_n   = line_addr(lk_tag, lk_set);
   assign evict_addr_n = line_addr(rd_tag[victim], lk_set);

   if (WRITE_THROUGH) begin : g_wt
      always_comb begin
         mark_dirty = 1'b0;
         evict_n    = 1'b0;
         if (lk_write) begin
            kind_n = MK_WRITE;
            done_n = 1'b1;
         end else begin
            kind_n = hit ? MK_NONE : MK_FETCH;
            done_n = hit;
         end
      end
   end else begin : g_wb
      always_comb begin
         mark_dirty = accept && hit && lk_write;
         evict_n    = !hit && !any_free && rd_dirty[victim];
         kind_n     = hit ? MK_NONE : MK_FETCH;
         done_n     = hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid    <= 1'b0;
         res_hit      <= 1'b0;
         res_way      <= '0;
         res_victim   <= '0;
         res_done     <= 1'b0;
         evict_valid  <= 1'b0;
         evict_addr   <= '0;
         kind_q       <= MK_NONE;
         mem_req_addr <= '0;
      end else if (accept) begin
         res_valid    <= 1'b1;
         res_hit      <= hit;
         res_way      <= hit_way;
         res_victim   <= victim;
         res_done     <= done_n;
         evict_valid  <= evict_n;
         evict_addr   <= evict_addr_n;
         kind_q       <= kind_n;
         mem_req_addr <= mem_addr_n;
      end else begin
         res_valid   <= 1'b0;
         evict_valid <= 1'b0;
         kind_q      <= MK_NONE;
      end
   end

   assign mem_req_valid = (kind_q != MK_NONE);
   assign mem_req_write = (kind_q == MK_WRITE);

   // R11
   res_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(lk_valid && lk_ready));

   // R6
   evict_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |-> res_valid && !res_hit && mem_req_valid && !mem_req_write);

   if (WRITE_THROUGH) begin : g_wt_chk
      // R7
      wt_write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_req_valid && mem_req_write) |-> res_done && res_valid);
   end else begin : g_wb_chk
      // R5
      wb_quiet_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && res_hit) |-> !mem_req_valid && !evict_valid);
   end
endmodule

// File: tb/cache_tag_array_test.sv
`timescale 1ns/1ps
module cache_tag_array_test;
   localparam int SETS = 8;
   localparam int WAYS = 4;
   localparam int AMAX = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        lk_valid = 1'b0;
   logic [2:0]  lk_set = '0;
   logic [23:0] lk_tag = '0;
   logic        lk_write = 1'b0;
   logic        f_v [2];
   logic [2:0]  f_s [2];
   logic [1:0]  f_w [2];
   logic [23:0] f_t [2];

   logic        o_rdy [2], o_rv [2], o_hit [2], o_done [2], o_ev [2], o_mv [2], o_mw [2];
   logic [1:0]  o_way [2], o_vic [2];
   logic [31:0] o_ea [2], o_ma [2];

   cache_tag_array #(.WRITE_THROUGH(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(o_rdy[0]),
      .lk_set(lk_set), .lk_tag(lk_tag), .lk_write(lk_write),
      .fill_valid(f_v[0]), .fill_set(f_s[0]), .fill_way(f_w[0]), .fill_tag(f_t[0]),
      .res_valid(o_rv[0]), .res_hit(o_hit[0]), .res_way(o_way[0]), .res_victim(o_vic[0]),
      .res_done(o_done[0]), .evict_valid(o_ev[0]), .evict_addr(o_ea[0]),
      .mem_req_valid(o_mv[0]), .mem_req_write(o_mw[0]), .mem_req_addr(o_ma[0]));

   cache_tag_array #(.WRITE_THROUGH(1'b1)) uut_wt (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(o_rdy[1]),
      .lk_set(lk_set), .lk_tag(lk_tag), .lk_write(lk_write),
      .fill_valid(f_v[1]), .fill_set(f_s[1]), .fill_way(f_w[1]), .fill_tag(f_t[1]),
      .res_valid(o_rv[1]), .res_hit(o_hit[1]), .res_way(o_way[1]), .res_victim(o_vic[1]),
      .res_done(o_done[1]), .evict_valid(o_ev[1]), .evict_addr(o_ea[1]),
      .mem_req_valid(o_mv[1]), .mem_req_write(o_mw[1]), .mem_req_addr(o_ma[1]));

   bit mvd [2][SETS][WAYS];
   bit mdt [2][SETS][WAYS];
   int mtg [2][SETS][WAYS];
   int mag [2][SETS][WAYS];

   bit e_hit [2], e_done [2], e_ev [2], e_mv [2], e_mw [2];
   int e_way [2], e_vic [2];
   logic [31:0] e_ea [2], e_ma [2];

   int checks = 0;
   int errors = 0;

   function automatic logic [31:0] mk(input int t, input int s);
      return (32'(t) << 8) | (32'(s) << 5) | 32'h10;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic predict(input int m, input int s, input int tag, input bit wr);
      int na [WAYS];
      int best, bmax, inv;
      bit found;
      e_hit[m] = 0; e_way[m] = 0;
      for (int w = 0; w < WAYS; w++)
         if (mvd[m][s][w] && mtg[m][s][w] == tag) begin e_hit[m] = 1; e_way[m] = w; end
      for (int w = 0; w < WAYS; w++) begin
         if (!mvd[m][s][w]) na[w] = mag[m][s][w];
         else if (mtg[m][s][w] == tag) na[w] = 0;
         else na[w] = (mag[m][s][w] == AMAX) ? AMAX : mag[m][s][w] + 1;
      end
      best = 0; bmax = 0;
      for (int w = 0; w < WAYS; w++)
         if (mvd[m][s][w] && na[w] > bmax) begin bmax = na[w]; best = w; end
      found = 0; inv = 0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!mvd[m][s][w]) begin found = 1; inv = w; end
      e_vic[m] = found ? inv : best;
      e_ma[m] = mk(tag, s);
      e_ea[m] = mk(mtg[m][s][e_vic[m]], s);
      if (m == 0) begin
         e_done[m] = e_hit[m];
         e_ev[m] = !e_hit[m] && !found && mdt[m][s][e_vic[m]];
         e_mv[m] = !e_hit[m];
         e_mw[m] = 0;
         if (e_hit[m] && wr) mdt[m][s][e_way[m]] = 1;
      end else begin
         e_ev[m] = 0;
         if (wr) begin e_mv[m] = 1; e_mw[m] = 1; e_done[m] = 1; end
         else begin e_mv[m] = !e_hit[m]; e_mw[m] = 0; e_done[m] = e_hit[m]; end
      end
      for (int w = 0; w < WAYS; w++) mag[m][s][w] = na[w];
   endtask

   task automatic lookup(input int s, input int tag, input bit wr);
      for (int m = 0; m < 2; m++) predict(m, s, tag, wr);
      @(negedge clk);
      lk_valid = 1'b1; lk_set = 3'(s); lk_tag = 24'(tag); lk_write = wr;
      @(negedge clk);
      lk_valid = 1'b0;
      for (int m = 0; m < 2; m++) begin
         chk("R11 result one cycle after accept", o_rv[m], 1);
         chk("R2 hit flag", o_hit[m], e_hit[m]);
         if (e_hit[m]) chk("R2 hit way", o_way[m], e_way[m]);
         chk("R4 victim way", o_vic[m], e_vic[m]);
         chk("R9 done flag", o_done[m], e_done[m]);
         chk("R6 evict flag", o_ev[m], e_ev[m]);
         if (e_ev[m]) chk("R6 evict address", o_ea[m], e_ea[m]);
         chk("R9 memory request valid", o_mv[m], e_mv[m]);
         if (e_mv[m]) begin
            chk("R9 memory request kind", o_mw[m], e_mw[m]);
            chk("R9 memory request address", o_ma[m], e_ma[m]);
         end
      end
   endtask

   task automatic fill_one(input int m, input int s, input int w, input int tag);
      @(negedge clk);
      f_v[m] = 1'b1; f_s[m] = 3'(s); f_w[m] = 2'(w); f_t[m] = 24'(tag);
      #1;
      chk("R10 lookup stalled during fill", o_rdy[m], 0);
      @(negedge clk);
      f_v[m] = 1'b0;
      mvd[m][s][w] = 1; mdt[m][s][w] = 0; mtg[m][s][w] = tag; mag[m][s][w] = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R11 watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int m = 0; m < 2; m++) begin f_v[m] = 0; f_s[m] = 0; f_w[m] = 0; f_t[m] = 0; end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         chk("R1 no result after reset", o_rv[m], 0);
         chk("R1 ready after reset", o_rdy[m], 1);
      end
      lookup(0, 5, 0);
      for (int m = 0; m < 2; m++) begin
         chk("R1 empty set misses", o_hit[m], 0);
         chk("R1 empty set victim", o_vic[m], 0);
         chk("R9 fetch on read miss", o_mw[m], 0);
         chk("R9 fetch address", o_ma[m], mk(5, 0));
      end
      for (int m = 0; m < 2; m++)
         for (int w = 0; w < WAYS; w++) fill_one(m, 1, w, 10 + w);
      repeat (4) lookup(1, 10, 0);
      for (int m = 0; m < 2; m++) chk("R3 saturated ages pick first oldest", o_vic[m], 1);
      lookup(1, 11, 0);
      for (int m = 0; m < 2; m++) chk("R3 hit way age cleared", o_vic[m], 2);
      lookup(1, 13, 0);
      for (int m = 0; m < 2; m++) begin
         chk("R10 filled way hits", o_hit[m], 1);
         chk("R10 filled way index", o_way[m], 3);
      end
      for (int t = 10; t < 14; t++) begin
         lookup(1, t, 1);
         chk("R5 write-back hit is quiet", o_mv[0], 0);
         chk("R7 write-through hit forwards", o_mw[1], 1);
      end
      lookup(1, 99, 0);
      chk("R6 dirty victim evicted", o_ev[0], 1);
      chk("R6 no evict in write-through", o_ev[1], 0);
      lookup(1, 10, 1);
      chk("R7 forward address", o_ma[1], mk(10, 1));
      chk("R7 forward done", o_done[1], 1);
      lookup(2, 77, 1);
      chk("R8 write miss done", o_done[1], 1);
      chk("R8 write miss forwards", o_mw[1], 1);
      lookup(2, 77, 0);
      chk("R8 no allocation on write miss", o_hit[1], 0);

      for (int i = 0; i < 800; i++) begin
         int s, tag;
         bit wr;
         s = int'($urandom_range(0, 3));
         tag = 20 + int'($urandom_range(0, 6));
         wr = ($urandom_range(0, 2) == 0);
         lookup(s, tag, wr);
         for (int m = 0; m < 2; m++)
            if (e_mv[m] && !e_mw[m] && $urandom_range(0, 3) != 0)
               fill_one(m, s, e_vic[m], tag);
         if ($urandom_range(0, 7) == 0) begin
            @(negedge clk);
            for (int m = 0; m < 2; m++) chk("R11 no result when idle", o_rv[m], 0);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule